// File: doc/BRIEF.md
# Capture Channel Reset Controller

This block resets a single video capture channel on software request. The channel control register sits in the bus clock domain. Software writes it with the reset bit set. The controller then clears the channel enable bit and raises a busy flag. It passes the request into the channel's pixel clock domain through a two-flop level synchronizer. In the pixel domain the capture FIFO read and write pointers are flushed to zero and held there for a fixed number of pixel cycles. The pixel domain then raises an acknowledge, which returns through a matching synchronizer.

The handshake is four-phase. Once the bus side sees the acknowledge, it drops the request and waits for the acknowledge to fall. It then loads the control register with its default value. That load clears the reset bit and the busy flag in the same cycle. If the pixel clock is stopped, the handshake cannot move and the reset stays pending. Bus reads are acknowledged on the next cycle at all times, so a DMA engine that polls the channel never stalls.

Top module: `cap_chan_reset_ctrl`

## Requirements
- R1: A write with the reset bit (bit 15) set, while no reset is pending, makes `reset_busy` 1 on the next bus cycle. In the same update the reset bit of `ctrl_q` becomes 1 and the enable bit (bit 0) becomes 0. The other bits keep their value.
- R2: The reset finishes only if the pixel clock toggles. While the pixel clock is stopped, `reset_busy` stays 1 for any number of bus cycles. The reset finishes after the clock resumes.
- R3: When the reset finishes, `ctrl_q` holds the default value 16'h0A50, with the enable and reset bits both 0.
- R4: When the reset finishes, both FIFO pointers read 0. They stay 0 until the next push or pop.
- R5: Outside a reset, each `fifo_push` pulse adds 1 to the write pointer and each `fifo_pop` pulse adds 1 to the read pointer, both modulo 32.
- R6: `reset_busy` and the reset bit of `ctrl_q` stay 1 from the start of a reset until it finishes. They fall in the same cycle in which `ctrl_q` takes its default value.
- R7: Every `rd_en` pulse gives `rd_ready` = 1 on the next bus cycle, including while a reset is pending. A read taken while no reset is pending returns `ctrl_q`. A read taken during a reset may return any value.
- R8: While a reset is pending, writes have no effect on `ctrl_q`, including writes with the reset bit set. Such writes also do not start a second reset.
- R9: A write with the reset bit clear, while no reset is pending, loads `wr_data` into `ctrl_q` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Synchronous active-low reset, bus domain |
| wr_en | input | 1 | Write strobe for the channel control register |
| wr_data | input | 16 | Write data; bit 15 is the reset bit, bit 0 the enable bit |
| rd_en | input | 1 | Read strobe for the channel control register |
| rd_ready | output | 1 | Read acknowledge, one cycle after `rd_en` |
| rd_data | output | 16 | Read data |
| ctrl_q | output | 16 | Current channel control register |
| reset_busy | output | 1 | High while a channel reset is pending |
| clk_pix | input | 1 | Channel pixel input clock; may stop |
| rst_pix_n | input | 1 | Synchronous active-low reset, pixel domain |
| fifo_push | input | 1 | FIFO write pulse, pixel domain |
| fifo_pop | input | 1 | FIFO read pulse, pixel domain |
| fifo_wr_ptr | output | 5 | Capture FIFO write pointer |
| fifo_rd_ptr | output | 5 | Capture FIFO read pointer |

## Verification
A lost or stuck handshake level shows as `reset_busy` that never falls, or that falls while the pixel clock is stopped. Either case appears within a few cycles of the expected completion. A bus state machine that ends early or in the wrong state leaves `ctrl_q` different from the default on the very cycle busy drops. The same fault shows if a write lands during the pending window. A flush that is skipped or released too soon leaves a nonzero pointer at completion. Pointer counts are compared on every pixel clock, so a missed or doubled increment shows on the next edge.

// File: rtl/cap_rst_pkg.sv
// Shared types for the capture channel reset controller.
// Assumes: included ahead of every module that uses the bus state type.
package cap_rst_pkg;
    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_REQ  = 2'd1,
        BS_REL  = 2'd2
    } bus_state_t;
endpackage

// File: rtl/cap_rst_sync.sv
// Multi-stage level synchronizer into the clock domain of clk.
// Assumes: d is a slowly changing level held until the far side acknowledges.
module cap_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop capture of the foreign level
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the foreign level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_rst_bus_side.sv
// Bus-domain part: control register, read acknowledge and the four-phase
// request side of the reset handshake.
// Assumes: ack_sync is already synchronized into clk.
module cap_rst_bus_side
    import cap_rst_pkg::*;
#(
    parameter int              REG_W     = 16,
    parameter int              EN_BIT    = 0,
    parameter int              RST_BIT   = 15,
    parameter logic [REG_W-1:0] RESET_VAL = 16'h0A50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic             ack_sync,
    output logic             req_o,
    output logic             busy_o,
    output logic [REG_W-1:0] ctrl_o,
    output logic             rd_ready_o,
    output logic [REG_W-1:0] rd_data_o
);
    localparam logic [REG_W-1:0] CTRL_MASK = ~((REG_W'(1) << EN_BIT) | (REG_W'(1) << RST_BIT));
    localparam logic [REG_W-1:0] DEF_VAL   = RESET_VAL & CTRL_MASK;

    bus_state_t       state;
    logic [REG_W-1:0] ctrl;
    logic             req;

    // Control register, request level and handshake state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BS_IDLE;
            ctrl  <= DEF_VAL;
            req   <= 1'b0;
        end else begin
            case (state)
                BS_IDLE: begin
                    if (wr_en) begin
                        if (wr_data[RST_BIT]) begin
                            ctrl[EN_BIT]  <= 1'b0;
                            ctrl[RST_BIT] <= 1'b1;
                            req           <= 1'b1;
                            state         <= BS_REQ;
                        end else begin
                            ctrl <= wr_data;
                        end
                    end
                end
                BS_REQ: begin
                    if (ack_sync) begin
                        req   <= 1'b0;
                        state <= BS_REL;
                    end
                end
                BS_REL: begin
                    if (!ack_sync) begin
                        ctrl  <= DEF_VAL;
                        state <= BS_IDLE;
                    end
                end
                default: state <= BS_IDLE;
            endcase
        end
    end

    // Read acknowledge and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ready_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_ready_o <= rd_en;
            if (rd_en) rd_data_o <= ctrl;
        end
    end

    assign req_o  = req;
    assign busy_o = (state != BS_IDLE);
    assign ctrl_o = ctrl;

    a_r7_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_ready_o);
    a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && wr_en && wr_data[RST_BIT]) |=> (busy_o && ctrl[RST_BIT] && !ctrl[EN_BIT]));
    a_r6_bit_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == ctrl[RST_BIT]);
    a_r3_default_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (ctrl == DEF_VAL));
    a_r8_pending_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_REQ && wr_en) |=> $stable(ctrl));
endmodule

// File: rtl/cap_rst_pix_side.sv
// Pixel-domain part: FIFO pointers and the flush sequence that answers a
// synchronized reset request with an acknowledge level.
// Assumes: req_sync is synchronized into clk; clk may stop at any time.
module cap_rst_pix_side #(
    parameter int PTR_W        = 5,
    parameter int FLUSH_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sync,
    input  logic             push,
    input  logic             pop,
    output logic             ack_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o
);
    localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);

    logic [CNT_W-1:0] flush_cnt;
    logic             ack;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Flush hold counter and acknowledge level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_cnt <= '0;
            ack       <= 1'b0;
        end else if (req_sync) begin
            if (flush_cnt != CNT_W'(FLUSH_CYCLES)) flush_cnt <= flush_cnt + CNT_W'(1);
            ack <= (flush_cnt == CNT_W'(FLUSH_CYCLES));
        end else begin
            flush_cnt <= '0;
            ack       <= 1'b0;
        end
    end

    // Pointer counting, held at zero while a flush is requested
    always_ff @(posedge clk) begin
        if (!rst_n || req_sync) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    assign ack_o    = ack;
    assign wr_ptr_o = wr_ptr;
    assign rd_ptr_o = rd_ptr;

    a_r4_flush_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (wr_ptr == '0 && rd_ptr == '0));
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req_sync));
endmodule

// File: rtl/cap_chan_reset_ctrl.sv
// Capture channel reset controller top: bus-side register and handshake,
// two synchronizers, and the pixel-side flush.
// Assumes: clk_bus and clk_pix are unrelated; clk_pix may be stopped.
module cap_chan_reset_ctrl #(
    parameter int              REG_W        = 16,
    parameter int              EN_BIT       = 0,
    parameter int              RST_BIT      = 15,
    parameter logic [REG_W-1:0] RESET_VAL    = 16'h0A50,
    parameter int              PTR_W        = 5,
    parameter int              SYNC_STAGES  = 2,
    parameter int              FLUSH_CYCLES = 2
) (
    input  logic             clk_bus,
    input  logic             rst_bus_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic             rd_ready,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] ctrl_q,
    output logic             reset_busy,
    input  logic             clk_pix,
    input  logic             rst_pix_n,
    input  logic             fifo_push,
    input  logic             fifo_pop,
    output logic [PTR_W-1:0] fifo_wr_ptr,
    output logic [PTR_W-1:0] fifo_rd_ptr
);
    logic req_bus;
    logic req_pix;
    logic ack_pix;
    logic ack_bus;

    cap_rst_bus_side #(
        .REG_W(REG_W), .EN_BIT(EN_BIT), .RST_BIT(RST_BIT), .RESET_VAL(RESET_VAL)
    ) bus_i (
        .clk(clk_bus), .rst_n(rst_bus_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .ack_sync(ack_bus), .req_o(req_bus), .busy_o(reset_busy),
        .ctrl_o(ctrl_q), .rd_ready_o(rd_ready), .rd_data_o(rd_data)
    );

    cap_rst_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk(clk_pix), .rst_n(rst_pix_n), .d(req_bus), .q(req_pix)
    );

    cap_rst_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(ack_pix), .q(ack_bus)
    );

    cap_rst_pix_side #(.PTR_W(PTR_W), .FLUSH_CYCLES(FLUSH_CYCLES)) pix_i (
        .clk(clk_pix), .rst_n(rst_pix_n), .req_sync(req_pix), .push(fifo_push),
        .pop(fifo_pop), .ack_o(ack_pix), .wr_ptr_o(fifo_wr_ptr), .rd_ptr_o(fifo_rd_ptr)
    );
endmodule

// File: tb/cap_chan_reset_ctrl_tb_top.sv
module cap_chan_reset_ctrl_tb_top;
    localparam logic [15:0] DEF = 16'h0A50;

    logic clk_bus = 1'b0, clk_pix = 1'b0, pix_run = 1'b1;
    logic rst_bus_n = 1'b0, rst_pix_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, fifo_push = 1'b0, fifo_pop = 1'b0;
    logic [15:0] wr_data = '0;
    logic rd_ready, reset_busy;
    logic [15:0] rd_data, ctrl_q;
    logic [4:0] fifo_wr_ptr, fifo_rd_ptr;

    int n_cmp = 0, n_bad = 0, bus_cyc = 0, pix_edges = 0, edges_at_req = 0;
    bit done = 0;

    // bus-domain model
    logic [15:0] m_reg = DEF, m_rd = '0;
    bit m_busy = 0, m_rdy = 0, m_rd_valid = 0;
    // pixel-domain model
    int m_wp = 0, m_rp = 0;

    cap_chan_reset_ctrl dut_i (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_ready(rd_ready), .rd_data(rd_data), .ctrl_q(ctrl_q),
        .reset_busy(reset_busy), .clk_pix(clk_pix), .rst_pix_n(rst_pix_n),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop),
        .fifo_wr_ptr(fifo_wr_ptr), .fifo_rd_ptr(fifo_rd_ptr)
    );

    always #4 clk_bus = ~clk_bus;
    always begin
        #5;
        if (pix_run) clk_pix = ~clk_pix;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // bus model: compare, detect completion, then apply current inputs
    always @(negedge clk_bus) begin
        bus_cyc++;
        if (!rst_bus_n) begin
            m_reg = DEF; m_busy = 0; m_rdy = 0; m_rd = '0; m_rd_valid = 0;
        end else begin
            if (m_busy && !reset_busy) begin
                chk(ctrl_q == DEF, "R3 default at completion", ctrl_q, DEF);
                chk(pix_edges - edges_at_req >= 3, "R2 pixel clock ran", pix_edges - edges_at_req, 3);
                chk(fifo_wr_ptr == 0 && fifo_rd_ptr == 0, "R4 pointers zero at completion",
                    {fifo_wr_ptr, fifo_rd_ptr}, 0);
                m_busy = 0; m_reg = DEF;
            end
            chk(reset_busy == m_busy, "R2/R6 busy", reset_busy, m_busy);
            chk(ctrl_q == m_reg, "R1/R8/R9 ctrl", ctrl_q, m_reg);
            chk(ctrl_q[15] == reset_busy, "R6 reset bit equals busy", ctrl_q[15], reset_busy);
            chk(rd_ready == m_rdy, "R7 read ack", rd_ready, m_rdy);
            if (m_rd_valid) chk(rd_data == m_rd, "R7 read data", rd_data, m_rd);
            m_rdy = rd_en;
            if (rd_en) begin m_rd = m_reg; m_rd_valid = !m_busy; end
            if (wr_en && !m_busy) begin
                if (wr_data[15]) begin
                    m_reg[0] = 1'b0; m_reg[15] = 1'b1; m_busy = 1; edges_at_req = pix_edges;
                end else m_reg = wr_data;
            end
        end
    end

    // pixel model: pointer counts, zeroed while a reset is in flight
    always @(negedge clk_pix) begin
        pix_edges++;
        if (!rst_pix_n || m_busy || reset_busy) begin
            m_wp = 0; m_rp = 0;
        end else begin
            chk(fifo_wr_ptr == 5'(m_wp), "R5/R4 write pointer", fifo_wr_ptr, m_wp);
            chk(fifo_rd_ptr == 5'(m_rp), "R5/R4 read pointer", fifo_rd_ptr, m_rp);
            if (fifo_push) m_wp = (m_wp + 1) % 32;
            if (fifo_pop)  m_rp = (m_rp + 1) % 32;
        end
    end

    task automatic bus_wr(input logic [15:0] d);
        @(posedge clk_bus); #2; wr_en = 1; wr_data = d;
        @(posedge clk_bus); #2; wr_en = 0;
    endtask
    task automatic bus_rd();
        @(posedge clk_bus); #2; rd_en = 1;
        @(posedge clk_bus); #2; rd_en = 0;
    endtask
    task automatic pix_ops(input int pushes, input int pops);
        for (int i = 0; i < pushes || i < pops; i++) begin
            @(posedge clk_pix); #1; fifo_push = (i < pushes); fifo_pop = (i < pops);
        end
        @(posedge clk_pix); #1; fifo_push = 0; fifo_pop = 0;
    endtask
    task automatic wait_done();
        for (int i = 0; i < 300 && reset_busy; i++) @(posedge clk_bus);
        repeat (3) @(posedge clk_bus);
        chk(!reset_busy, "R2 completion with running clock", reset_busy, 0);
    endtask

    initial begin
        repeat (6) @(posedge clk_bus);
        #2; rst_bus_n = 1; rst_pix_n = 1;
        @(posedge clk_bus); #2;
        chk(ctrl_q == DEF && !reset_busy && fifo_wr_ptr == 0, "R3 reset state", ctrl_q, DEF);
        bus_wr(16'h0123); bus_rd();                       // R9, R7
        pix_ops(7, 3);                                    // R5
        bus_wr(16'h4201); bus_rd();
        repeat (4) @(posedge clk_bus);
        bus_wr(16'h8000);                                 // R1
        wait_done();                                      // R3, R4, R6
        bus_rd();
        pix_ops(5, 2);
        pix_run = 0;                                      // R2: stalled pixel clock
        bus_wr(16'h8001);
        bus_rd(); bus_wr(16'h1111); bus_wr(16'h8001);     // R7, R8
        repeat (100) @(posedge clk_bus);
        chk(reset_busy, "R2 pending while clock stopped", reset_busy, 1);
        pix_run = 1;
        wait_done();
        pix_ops(40, 33);                                  // R5 wrap
        bus_wr(16'h0203);
        bus_wr(16'h8203);
        repeat (3) @(posedge clk_bus);
        bus_wr(16'h7777); bus_rd();                       // R8 with clock running
        wait_done();
        pix_ops(2, 1);
        repeat (10) @(posedge clk_bus);
        done = 1;
    end

    initial begin
        wait (done || bus_cyc > 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", bus_cyc, 150000);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule